// File: doc/BRIEF.md
# Cascadable Configuration Bit Streamer

This block plays a stored configuration image out one bit at a time, so that a target FPGA can be loaded serially. The bits sit in an internal store that is filled beforehand through a simple one-bit write port. A hold input clears the sequencer and floats the data output. Its active level is chosen by a static polarity input. An active-low select enables counting and driving.

The role is fixed each time the hold is released. If select is low at that moment, the block is the chain head. It then generates the bit clock on a bidirectional clock pin by dividing the system clock. If select is high, the block waits as a follower and counts rising edges of an external clock that arrive on the same pin. When the image is exhausted, the block pulls its chain output low and floats its data output, so the next device in the chain can take over. After completion, the head waits for its target to deselect it. It then gives a fixed burst of trailing clocks and goes quiet. The head flags a fault when select rises too early, or when select never rises after the image has been sent.

Top module: `cfg_stream_seq`

## Requirements
- R1: While hold is active, or while the power-up interval runs, `bit_oe_o` is 0, `chain_n_o` is 1 and `fault_o` is 0. On the first cycle after the hold is released, the stream restarts at store bit 0.
- R2: The role is captured from `sel_n_i` on the last cycle of hold. Select low makes the block the head, with `bclk_oe_o`=1. Select high makes it a follower, with `bclk_oe_o`=0. The role does not change until the next hold.
- R3: `bit_oe_o` is never 1 while `sel_n_i` is 1. A follower whose select is high ignores clock edges, so after it is selected the first bit presented is still store bit 0.
- R4: A selected head drives `bclk_o` with high and low phases of HALF_PERIOD system cycles each. Every rising edge of `bclk_o` consumes the bit that was on `bit_o` just before it. The bits go out in store order, from index 0 to DEPTH-1.
- R5: A selected follower advances one bit for each rising edge of `bclk_i`. The edge passes through a two-flop synchronizer, so the new bit appears three system edges after the pin rises.
- R6: The rising clock that takes the last bit ends the stream. `chain_n_o` then goes 0, `bit_oe_o` goes 0 and the head's clock stays low.
- R7: After completion, when the head sees `sel_n_i` go high, it gives exactly TRAIL_CLKS further rising clock edges. It then holds `bclk_o` low until the next hold.
- R8: A head whose select goes high before the last bit has gone out sets `fault_o`. The fault stays set until the next hold.
- R9: A head that has finished and still sees select low after DONE_TIMEOUT system cycles sets `fault_o`. A follower never raises this fault.
- R10: With `hold_pol_i`=1, the hold is active when `hold_i`=1. With `hold_pol_i`=0, the hold is active when `hold_i`=0.
- R11: `rdy_o` is 0 for POR_CYCLES cycles after `rst_n` is released. It then rises and stays at 1.
- R12: A write with `wr_en_i`=1 stores `wr_bit_i` at index `wr_addr_i`. Index i is the (i+1)-th bit that is streamed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| wr_en_i | input | 1 | Store write strobe |
| wr_addr_i | input | AW | Store bit index for a write |
| wr_bit_i | input | 1 | Bit value to write |
| hold_pol_i | input | 1 | 1: hold active high; 0: hold active low |
| hold_i | input | 1 | Hold (reset) / output-enable input |
| sel_n_i | input | 1 | Select, active low |
| bclk_i | input | 1 | External bit clock (follower role) |
| bclk_o | output | 1 | Generated bit clock (head role) |
| bclk_oe_o | output | 1 | Clock pin drive enable (1 in head role) |
| bit_o | output | 1 | Serial data, 0 when not enabled |
| bit_oe_o | output | 1 | Data pin drive enable |
| chain_n_o | output | 1 | Chain handoff, low once the image is exhausted |
| rdy_o | output | 1 | Ready flag, low during power-up interval |
| fault_o | output | 1 | Sticky configuration fault |

## Verification
The data enable follows select in the same cycle, so the bench samples it on the next falling edge. A hold or select change takes effect in state one system edge later, so the bench waits two falling edges before checking a role, a fault or the chain output. A follower bit changes three edges after its clock pin rises. The bench therefore keeps each external pulse high for at least four cycles and low for at least three, and compares data only after the low phase. Head bits and trailing edges are not tied to a cycle number. Instead, the bench watches for each 0-to-1 change of the clock pin and credits the bit seen on the sample just before it. The timeout fault is checked a few cycles before and after its due edge, which is DONE_TIMEOUT cycles after the chain output falls.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

    typedef enum logic [2:0] {
        ST_WAIT   = 3'd0,
        ST_STREAM = 3'd1,
        ST_DONE   = 3'd2,
        ST_TRAIL  = 3'd3,
        ST_IDLE   = 3'd4
    } seq_state_e;

    function automatic logic is_finished(input seq_state_e st);
        return (st == ST_DONE) || (st == ST_TRAIL) || (st == ST_IDLE);
    endfunction

endpackage

// File: rtl/cfg_bit_store.sv
module cfg_bit_store #(
    parameter int unsigned DEPTH = 256,
    parameter int unsigned AW    = 8
) (
    input  logic          clk,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic          wr_bit_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic          rd_bit_o
);
    logic [DEPTH-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (wr_en_i && (32'(wr_addr_i) < DEPTH)) begin
            mem_d[wr_addr_i] = wr_bit_i;
        end
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    assign rd_bit_o = mem_q[rd_addr_i];
endmodule

// File: rtl/cfg_clk_div.sv
module cfg_clk_div #(
    parameter int unsigned HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic phase_o,
    output logic rise_o
);
    localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] CMAX = CW'(HALF - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ph;
    } div_t;

    div_t d, q;

    always_comb begin
        d = q;
        if (!en_i) begin
            d.cnt = '0;
            d.ph  = 1'b0;
        end else if (q.cnt == CMAX) begin
            d.cnt = '0;
            d.ph  = ~q.ph;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign phase_o = q.ph;
    assign rise_o  = en_i && (q.cnt == CMAX) && !q.ph;
endmodule

// File: rtl/cfg_edge_sync.sv
module cfg_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

    sync_t d, q;

    always_comb begin
        d.s1 = pin_i;
        d.s2 = q.s1;
        d.s3 = q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rise_o = q.s2 && !q.s3;
endmodule

// File: rtl/cfg_stream_seq.sv
module cfg_stream_seq
    import cfg_seq_pkg::*;
#(
    parameter int unsigned DEPTH        = 256,
    parameter int unsigned HALF_PERIOD  = 4,
    parameter int unsigned TRAIL_CLKS   = 16,
    parameter int unsigned DONE_TIMEOUT = 1000,
    parameter int unsigned POR_CYCLES   = 16,
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic          wr_bit_i,
    input  logic          hold_pol_i,
    input  logic          hold_i,
    input  logic          sel_n_i,
    input  logic          bclk_i,
    output logic          bclk_o,
    output logic          bclk_oe_o,
    output logic          bit_o,
    output logic          bit_oe_o,
    output logic          chain_n_o,
    output logic          rdy_o,
    output logic          fault_o
);
    localparam int unsigned TW = $clog2(TRAIL_CLKS + 1);
    localparam int unsigned MW = $clog2(DONE_TIMEOUT + 1);
    localparam int unsigned PW = $clog2(POR_CYCLES + 1);
    localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);
    localparam logic [TW-1:0] TRAIL_END = TW'(TRAIL_CLKS);
    localparam logic [MW-1:0] TMO_END   = MW'(DONE_TIMEOUT - 1);
    localparam logic [PW-1:0] POR_END   = PW'(POR_CYCLES - 1);

    typedef struct packed {
        seq_state_e    st;
        logic [AW-1:0] addr;
        logic          head;
        logic          fault;
        logic [TW-1:0] trail;
        logic [MW-1:0] tmo;
        logic [PW-1:0] por;
        logic          por_done;
    } ctl_t;

    ctl_t d, q;

    logic in_hold, gen_en, gen_phase, gen_rise, ext_rise, tick, rd_bit;

    cfg_bit_store #(.DEPTH(DEPTH), .AW(AW)) i_store (
        .clk       (clk),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_bit_i  (wr_bit_i),
        .rd_addr_i (q.addr),
        .rd_bit_o  (rd_bit)
    );

    cfg_clk_div #(.HALF(HALF_PERIOD)) i_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (gen_en),
        .phase_o (gen_phase),
        .rise_o  (gen_rise)
    );

    cfg_edge_sync i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (bclk_i),
        .rise_o (ext_rise)
    );

    always_comb begin
        in_hold = !q.por_done || (hold_i == hold_pol_i);
        gen_en  = !in_hold && q.head &&
                  (((q.st == ST_STREAM) && !sel_n_i) ||
                   ((q.st == ST_TRAIL) && ((q.trail != TRAIL_END) || gen_phase)));
        tick    = q.head ? gen_rise : ext_rise;
    end

    always_comb begin
        d = q;
        if (!q.por_done) begin
            if (q.por == POR_END) d.por_done = 1'b1;
            else                  d.por      = q.por + 1'b1;
        end
        if (in_hold) begin
            d.st    = ST_WAIT;
            d.addr  = '0;
            d.fault = 1'b0;
            d.trail = '0;
            d.tmo   = '0;
            d.head  = !sel_n_i;
        end else begin
            unique case (q.st)
                ST_WAIT: begin
                    if (sel_n_i && q.head) d.fault = 1'b1;
                    if (!sel_n_i)          d.st    = ST_STREAM;
                end
                ST_STREAM: begin
                    if (sel_n_i) begin
                        if (q.head) d.fault = 1'b1;
                        d.st = ST_WAIT;
                    end else if (tick) begin
                        if (q.addr == LAST_ADDR) d.st   = ST_DONE;
                        else                     d.addr = q.addr + 1'b1;
                    end
                end
                ST_DONE: begin
                    if (sel_n_i) begin
                        d.st = q.head ? ST_TRAIL : ST_IDLE;
                    end else if (q.head) begin
                        if (q.tmo == TMO_END) d.fault = 1'b1;
                        else                  d.tmo   = q.tmo + 1'b1;
                    end
                end
                ST_TRAIL: begin
                    if (tick) d.trail = q.trail + 1'b1;
                    if ((q.trail == TRAIL_END) && !gen_phase) d.st = ST_IDLE;
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_WAIT;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        bit_oe_o  = !in_hold && !sel_n_i && !is_finished(q.st);
        bit_o     = bit_oe_o && rd_bit;
        chain_n_o = in_hold || !is_finished(q.st);
        bclk_o    = q.head && gen_phase;
        bclk_oe_o = q.head;
        rdy_o     = q.por_done;
        fault_o   = q.fault;
    end
endmodule

// File: rtl/cfg_stream_seq_chk.sv
module cfg_stream_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic hold_pol_i,
    input logic hold_i,
    input logic sel_n_i,
    input logic bclk_o,
    input logic bclk_oe_o,
    input logic bit_oe_o,
    input logic chain_n_o,
    input logic rdy_o,
    input logic fault_o
);
    logic held;
    assign held = !rdy_o || (hold_i == hold_pol_i);

    // R1: first cycle out of hold starts clean
    a_r1_clean_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (!held && $past(held)) |-> (chain_n_o && !fault_o));

    // R2: role pin enable is fixed outside hold
    a_r2_role_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!held && $past(!held)) |-> $stable(bclk_oe_o));

    // R3: data is driven only when selected
    a_r3_drive_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        bit_oe_o |-> !sel_n_i);

    // R6: finished image floats the data pin
    a_r6_handoff_floats: assert property (@(posedge clk) disable iff (!rst_n)
        !chain_n_o |-> !bit_oe_o);

    // R7: clock stays low through a held interval
    a_r7_clock_low_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (held && $past(held)) |-> !bclk_o);

    // R8: fault is sticky outside hold
    a_r8_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!held && $past(!held) && $past(fault_o)) |-> fault_o);

    // R11: ready never drops once raised
    a_r11_ready_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rdy_o) |-> rdy_o);
endmodule

bind cfg_stream_seq cfg_stream_seq_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold_pol_i (hold_pol_i),
    .hold_i     (hold_i),
    .sel_n_i    (sel_n_i),
    .bclk_o     (bclk_o),
    .bclk_oe_o  (bclk_oe_o),
    .bit_oe_o   (bit_oe_o),
    .chain_n_o  (chain_n_o),
    .rdy_o      (rdy_o),
    .fault_o    (fault_o)
);

// File: tb/test_cfg_stream_seq.sv
`timescale 1ns/1ps
module test_cfg_stream_seq;
    localparam int DEPTH = 64;
    localparam int HALF  = 2;
    localparam int TRAIL = 16;
    localparam int TMO   = 40;
    localparam int POR   = 8;
    localparam int AW    = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic wr_bit = 1'b0;
    logic hold_pol = 1'b0;
    logic hold = 1'b0;
    logic sel_n = 1'b0;
    logic bclk_in = 1'b0;
    logic bclk_out, bclk_oe, bit_out, bit_oe, chain_n, rdy, fault;

    int checks = 0;
    int fails = 0;
    logic pat [DEPTH];

    always #2.5 clk = ~clk;

    cfg_stream_seq #(
        .DEPTH(DEPTH), .HALF_PERIOD(HALF), .TRAIL_CLKS(TRAIL),
        .DONE_TIMEOUT(TMO), .POR_CYCLES(POR)
    ) i_cfg_stream_seq (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_bit_i(wr_bit), .hold_pol_i(hold_pol), .hold_i(hold),
        .sel_n_i(sel_n), .bclk_i(bclk_in), .bclk_o(bclk_out),
        .bclk_oe_o(bclk_oe), .bit_o(bit_out), .bit_oe_o(bit_oe),
        .chain_n_o(chain_n), .rdy_o(rdy), .fault_o(fault)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int hold_level(input logic pol, input logic active);
        return active ? int'(pol) : int'(!pol);
    endfunction

    task automatic do_hold(input logic sel);
        hold  = hold_level(hold_pol, 1'b1);
        sel_n = sel;
        cyc(3);
        hold  = hold_level(hold_pol, 1'b0);
        cyc(2);
    endtask

    // Head streaming: credit the bit sampled just before each clock rise
    task automatic head_stream(input string req);
        int rises = 0;
        int mism = 0;
        int hi_run = 0;
        int first_hi = -1;
        logic prev_clk = bclk_out;
        logic prev_bit = bit_out;
        for (int t = 0; t < DEPTH * 4 * HALF + 50 && chain_n; t++) begin
            cyc(1);
            if (!prev_clk && bclk_out) begin
                if (rises < DEPTH && prev_bit !== pat[rises]) mism++;
                rises++;
                hi_run = 1;
            end else if (prev_clk && bclk_out) begin
                hi_run++;
            end else if (prev_clk && !bclk_out && first_hi < 0) begin
                first_hi = hi_run;
            end
            prev_clk = bclk_out;
            prev_bit = bit_out;
        end
        chk({req, " bit order mismatches"}, mism, 0);
        chk({req, " rise count"}, rises, DEPTH);
        chk("R4 high phase length", first_hi, HALF);
    endtask

    task automatic count_rises(input int span, output int n);
        logic prev = bclk_out;
        n = 0;
        for (int t = 0; t < span; t++) begin
            cyc(1);
            if (!prev && bclk_out) n++;
            prev = bclk_out;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int n;
        void'($urandom(32'h5eed));
        for (int i = 0; i < DEPTH; i++) pat[i] = 1'($urandom);
        pat[0] = 1'b1;
        pat[DEPTH-1] = 1'b1;
        hold = 1'b0;
        sel_n = 1'b0;
        cyc(1);
        chk("R11 ready low in power-up", rdy, 0);
        // R12 preload the store
        for (int i = 0; i < DEPTH; i++) begin
            wr_en = 1'b1; wr_addr = AW'(i); wr_bit = pat[i];
            cyc(1);
        end
        wr_en = 1'b0;
        rst_n = 1'b1;
        cyc(2);
        chk("R11 ready still low", rdy, 0);
        cyc(POR + 2);
        chk("R11 ready high", rdy, 1);
        chk("R1 data floats in hold", bit_oe, 0);
        chk("R1 chain high in hold", chain_n, 1);

        // Head stream, then trailing clocks
        hold = 1'b1;
        cyc(2);
        chk("R2 head drives clock pin", bclk_oe, 1);
        chk("R1 first bit is index 0", bit_out, pat[0]);
        head_stream("R4 R12");
        cyc(2);
        chk("R6 chain low at end", chain_n, 0);
        chk("R6 data floats at end", bit_oe, 0);
        chk("R6 clock low at end", bclk_out, 0);
        sel_n = 1'b1;
        count_rises(TRAIL * 2 * HALF + 40, n);
        chk("R7 trailing rises", n, TRAIL);
        chk("R7 clock low when idle", bclk_out, 0);
        chk("R8 no fault on proper deselect", fault, 0);

        // Missing deselect
        do_hold(1'b0);
        chk("R1 chain restored", chain_n, 1);
        for (int t = 0; t < DEPTH * 4 * HALF + 50 && chain_n; t++) cyc(1);
        cyc(TMO - 5);
        chk("R9 no fault before timeout", fault, 0);
        cyc(10);
        chk("R9 fault after timeout", fault, 1);
        do_hold(1'b0);
        chk("R1 fault cleared by hold", fault, 0);

        // Early deselect
        cyc(10 + $urandom_range(0, 20));
        sel_n = 1'b1;
        cyc(1);
        chk("R3 data floats when deselected", bit_oe, 0);
        cyc(1);
        chk("R8 early deselect fault", fault, 1);

        // Polarity: active-high hold
        hold_pol = 1'b1; hold = 1'b1; sel_n = 1'b0;
        cyc(3);
        chk("R10 high level holds", bit_oe, 0);
        chk("R10 fault cleared", fault, 0);
        hold = 1'b0;
        cyc(3);
        chk("R10 low level releases", bit_oe, 1);
        chk("R10 head role", bclk_oe, 1);
        hold = 1'b1;
        cyc(1);
        chk("R10 high level holds again", bit_oe, 0);
        hold_pol = 1'b0; hold = 1'b0;
        cyc(2);

        // Follower role
        do_hold(1'b1);
        chk("R2 follower releases clock pin", bclk_oe, 0);
        for (int k = 0; k < 3 + int'($urandom_range(0, 3)); k++) begin
            bclk_in = 1'b1; cyc(4);
            bclk_in = 1'b0; cyc(3);
        end
        chk("R3 no drive while deselected", bit_oe, 0);
        sel_n = 1'b0;
        cyc(2);
        chk("R3 counter frozen while deselected", bit_out, pat[0]);
        chk("R3 drive when selected", bit_oe, 1);
        begin
            int mism = 0;
            for (int k = 0; k < DEPTH; k++) begin
                if (bit_out !== pat[k]) mism++;
                bclk_in = 1'b1; cyc(4 + int'($urandom_range(0, 2)));
                bclk_in = 1'b0; cyc(3 + int'($urandom_range(0, 3)));
            end
            chk("R5 follower bit order mismatches", mism, 0);
        end
        chk("R6 follower chain low", chain_n, 0);
        chk("R6 follower data floats", bit_oe, 0);
        cyc(TMO + 10);
        chk("R9 follower never times out", fault, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule